// File: doc/BRIEF.md
# Scaled Integer and Reduced-Float Converter

This block converts in both directions between 10-bit two's-complement integers and an 18-bit reduced floating-point word. The float word holds a sign bit, an 8-bit exponent stored with an offset of 128, and a 9-bit fractional mantissa whose top bit is worth one half. It has no special values, no subnormals and no rounding. Each direction takes its own signed power-of-two scale. The scale lets small integers build values below one. It also lets a float be brought back into the narrow integer range.

The two conversion paths are independent and both run every clock cycle. Each path registers its result, so each output follows its inputs after one clock edge. Integer-to-float finds the leading one of the magnitude, shifts it to the mantissa top bit and folds the shift and the scale into the exponent. Float-to-integer turns the exponent and the scale into a right-shift count, truncates, and applies the sign again. Neither path checks for overflow. Out-of-range results wrap.

Top module: `scaled_fp_conv`

## Requirements
- R1: While `rst` is high at a rising edge, both `float_out` and `int_out` are zero after that edge.
- R2: Each output updates at the first rising edge after its inputs change and holds its value until that edge. The two paths do not affect each other.
- R3: An integer input of zero gives an all-zero float word, whatever the scale.
- R4: For a nonzero integer, `float_out` bit 17 equals the integer's bit 9. Bits 8:0 hold the magnitude shifted left until bit 8 is one.
- R5: The exponent field, bits 16:9, is the low 8 bits of 137 minus the left-shift count plus the scale. The scale is read as 8-bit two's complement. There is no range check.
- R6: The integer -512 is converted with its magnitude clamped to 511. This gives mantissa 0x1FF, sign 1 and exponent 137 plus the scale.
- R7: In float-to-integer, let the shift count be 137 plus the signed 8-bit scale minus the exponent field. When this count is positive, the magnitude is the 9-bit mantissa shifted right by that count, truncated. The magnitude is 0 when the count is 9 or more.
- R8: When that count is zero or negative, the mantissa is shifted left by its negation and only the low 9 bits are kept. There is no overflow detection.
- R9: When the float sign bit is set, the 9-bit magnitude is negated in 10-bit two's complement. A zero magnitude gives 0 with either sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| int_in | input | 10 | Two's-complement integer to convert to float |
| int_scale | input | 8 | Signed power-of-two scale applied to `int_in` |
| float_out | output | 18 | Registered float {sign, exponent, mantissa} |
| float_in | input | 18 | Float word to convert to integer |
| float_scale | input | 8 | Signed scale; the result is the value times 2^-scale |
| int_out | output | 10 | Registered two's-complement integer |

## Verification
Both conversions can complete on the same clock edge, because every applied vector drives a fresh integer and a fresh float word together. Each output is compared on its own against an arithmetic model in the bench. A mistake that leaks state or wiring from one path into the other therefore shows up as a miscompare on the path that should not have changed. The integer side is swept over all 1024 codes at several scales, including ones that wrap the exponent. Meanwhile the float side sees pseudo-random words, then a full exponent sweep that crosses the truncation, wrap and negative-zero boundaries.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
  localparam int FP_EXP_W  = 8;
  localparam int FP_MANT_W = 9;
  localparam int FP_BIAS   = 128;
  localparam int FP_W      = 1 + FP_EXP_W + FP_MANT_W;

  typedef struct packed {
    logic                 sign;
    logic [FP_EXP_W-1:0]  exp;
    logic [FP_MANT_W-1:0] mant;
  } sfc_float_t;
endpackage

// File: rtl/sfc_lead_one.sv
`timescale 1ns/1ps
// Leading-one locator: reports how far the highest set bit sits below the MSB.
module sfc_lead_one #(
  parameter int W = 9,
  localparam int LZ_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    vec,
  output logic [LZ_W-1:0] lz,
  output logic            all_zero
);
  always_comb begin
    lz = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) lz = LZ_W'(W - 1 - i);
    end
  end

  assign all_zero = ~|vec;
endmodule

// File: rtl/sfc_int_to_float.sv
`timescale 1ns/1ps
module sfc_int_to_float
  import sfc_pkg::*;
#(
  parameter int INT_W   = 10,
  parameter int SCALE_W = 8
) (
  input  logic [INT_W-1:0]   int_val,
  input  logic [SCALE_W-1:0] scale,
  output sfc_float_t         fl
);
  localparam int MAG_W = INT_W - 1;
  localparam int LZ_W  = $clog2(MAG_W + 1);

  logic                 neg;
  logic [INT_W-1:0]     abs_full;
  logic [MAG_W-1:0]     mag;
  logic [MAG_W-1:0]     norm;
  logic [LZ_W-1:0]      lz;
  logic                 is_zero;
  logic [FP_MANT_W-1:0] mant;
  logic [FP_EXP_W-1:0]  exp_val;

  assign neg      = int_val[INT_W-1];
  assign abs_full = neg ? (~int_val + 1'b1) : int_val;
  // R6: the most negative code has no 9-bit magnitude; clamp to all ones
  assign mag      = abs_full[INT_W-1] ? '1 : abs_full[MAG_W-1:0];

  sfc_lead_one #(.W(MAG_W)) u_lead (
    .vec      (mag),
    .lz       (lz),
    .all_zero (is_zero)
  );

  assign norm = mag << lz;

  generate
    if (FP_MANT_W >= MAG_W) begin : g_widen
      assign mant = FP_MANT_W'(norm) << (FP_MANT_W - MAG_W);
    end else begin : g_narrow
      assign mant = norm[MAG_W-1 -: FP_MANT_W];
    end
  endgenerate

  // R5: only the low exponent bits are kept, so modular arithmetic at the
  // field width gives the same bits as a wider sum
  assign exp_val = FP_EXP_W'(FP_BIAS + MAG_W) - FP_EXP_W'(lz)
                 + FP_EXP_W'({{(32-SCALE_W){scale[SCALE_W-1]}}, scale});

  // R3 / R4
  assign fl = is_zero ? '0 : '{sign: neg, exp: exp_val, mant: mant};
endmodule

// File: rtl/sfc_float_to_int.sv
`timescale 1ns/1ps
module sfc_float_to_int
  import sfc_pkg::*;
#(
  parameter int INT_W   = 10,
  parameter int SCALE_W = 8
) (
  input  sfc_float_t         fl,
  input  logic [SCALE_W-1:0] scale,
  output logic [INT_W-1:0]   int_val
);
  localparam int MAG_W  = INT_W - 1;
  localparam int CALC_W = FP_EXP_W + 2;

  logic signed [CALC_W-1:0] sh;
  logic [CALC_W-1:0]        lsh;
  logic [MAG_W-1:0]         mag;
  logic [INT_W-1:0]         mag_ext;

  // R7: right-shift count from exponent and scale, kept at 10 bits signed
  assign sh = $signed(CALC_W'(FP_BIAS + FP_MANT_W))
            + $signed({{(CALC_W-SCALE_W){scale[SCALE_W-1]}}, scale})
            - $signed({{(CALC_W-FP_EXP_W){1'b0}}, fl.exp});
  assign lsh = CALC_W'(-sh);

  always_comb begin
    if (sh > 0) begin
      mag = MAG_W'(fl.mant >> CALC_W'(sh));   // R7: truncating, 0 when >= 9
    end else begin
      mag = MAG_W'(fl.mant) << lsh;          // R8: wraps, no overflow check
    end
  end

  assign mag_ext = {1'b0, mag};
  // R9
  assign int_val = fl.sign ? (~mag_ext + 1'b1) : mag_ext;
endmodule

// File: rtl/scaled_fp_conv.sv
`timescale 1ns/1ps
module scaled_fp_conv
  import sfc_pkg::*;
#(
  parameter int INT_W   = 10,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INT_W-1:0]   int_in,
  input  logic [SCALE_W-1:0] int_scale,
  output logic [FP_W-1:0]    float_out,
  input  logic [FP_W-1:0]    float_in,
  input  logic [SCALE_W-1:0] float_scale,
  output logic [INT_W-1:0]   int_out
);
  sfc_float_t       fl_next;
  logic [INT_W-1:0] int_next;

  sfc_int_to_float #(.INT_W(INT_W), .SCALE_W(SCALE_W)) u_i2f (
    .int_val (int_in),
    .scale   (int_scale),
    .fl      (fl_next)
  );

  sfc_float_to_int #(.INT_W(INT_W), .SCALE_W(SCALE_W)) u_f2i (
    .fl      (sfc_float_t'(float_in)),
    .scale   (float_scale),
    .int_val (int_next)
  );

  // R1 / R2: one register stage per path
  always_ff @(posedge clk) begin
    if (rst) begin
      float_out <= '0;
      int_out   <= '0;
    end else begin
      float_out <= fl_next;
      int_out   <= int_next;
    end
  end
endmodule

// File: rtl/sfc_checker.sv
`timescale 1ns/1ps
module sfc_checker
  import sfc_pkg::*;
#(
  parameter int INT_W   = 10,
  parameter int SCALE_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [INT_W-1:0]   int_in,
  input logic [SCALE_W-1:0] int_scale,
  input logic [FP_W-1:0]    float_out,
  input logic [FP_W-1:0]    float_in,
  input logic [SCALE_W-1:0] float_scale,
  input logic [INT_W-1:0]   int_out
);
  int deep_sh;
  logic unused_scale;

  assign unused_scale = ^int_scale;
  assign deep_sh = FP_BIAS + FP_MANT_W + int'($signed(float_scale))
                 - int'(float_in[FP_W-2 -: FP_EXP_W]);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (float_out == '0 && int_out == '0)); // R1

  AST_ZERO_INT: assert property (@(posedge clk) disable iff (rst)
    (int_in == '0) |=> (float_out == '0)); // R3

  AST_NORM_MSB: assert property (@(posedge clk) disable iff (rst)
    (int_in != '0) |=> float_out[FP_MANT_W-1]); // R4

  AST_SIGN_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (int_in != '0) |=> (float_out[FP_W-1] == $past(int_in[INT_W-1]))); // R4

  AST_CLAMP_MIN: assert property (@(posedge clk) disable iff (rst)
    (int_in == {1'b1, {(INT_W-1){1'b0}}}) |=> (float_out[FP_MANT_W-1:0] == '1 && float_out[FP_W-1])); // R6

  AST_DEEP_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (deep_sh >= FP_MANT_W) |=> (int_out == '0)); // R7

  AST_ZERO_MANT: assert property (@(posedge clk) disable iff (rst)
    (float_in[FP_MANT_W-1:0] == '0) |=> (int_out == '0)); // R9
endmodule

bind scaled_fp_conv sfc_checker #(.INT_W(INT_W), .SCALE_W(SCALE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .int_in      (int_in),
  .int_scale   (int_scale),
  .float_out   (float_out),
  .float_in    (float_in),
  .float_scale (float_scale),
  .int_out     (int_out)
);

// File: tb/tb_scaled_fp_conv.sv
`timescale 1ns/1ps
module tb_scaled_fp_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  int_in = '0;
  logic [7:0]  int_scale = '0;
  logic [17:0] float_in = '0;
  logic [7:0]  float_scale = '0;
  logic [17:0] float_out;
  logic [9:0]  int_out;

  int vectors = 0;
  int fails   = 0;
  logic [17:0] last_fl;
  logic [9:0]  last_int;

  always #2.5 clk = ~clk;

  scaled_fp_conv dut (
    .clk(clk), .rst(rst), .int_in(int_in), .int_scale(int_scale),
    .float_out(float_out), .float_in(float_in), .float_scale(float_scale),
    .int_out(int_out)
  );

  function automatic logic [17:0] ref_i2f(int v, int s);
    int mag, p, sh, e, m;
    if (v == 0) return '0;
    mag = (v < 0) ? -v : v;
    if (mag > 511) mag = 511;
    p = 0;
    for (int b = 0; b < 9; b++) if (((mag >> b) & 1) == 1) p = b;
    sh = 8 - p;
    e  = (137 - sh + s) & 255;
    m  = (mag << sh) & 511;
    return {(v < 0), e[7:0], m[8:0]};
  endfunction

  function automatic int f2i_shift(logic [17:0] f, int s);
    return 137 + s - int'(f[16:9]);
  endfunction

  function automatic logic [9:0] ref_f2i(logic [17:0] f, int s);
    int sh, m, mag;
    m  = int'(f[8:0]);
    sh = f2i_shift(f, s);
    if (sh > 0) mag = (sh >= 9) ? 0 : (m >> sh);
    else        mag = (-sh >= 9) ? 0 : ((m << (-sh)) & 511);
    if (f[17]) mag = -mag;
    return mag[9:0];
  endfunction

  task automatic check_val(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic apply(int iv, int is, logic [17:0] fv, int fs);
    string ti, tf;
    int sh;
    @(negedge clk);
    int_in = iv[9:0]; int_scale = is[7:0]; float_in = fv; float_scale = fs[7:0];
    @(negedge clk);
    last_fl  = ref_i2f(iv, is);
    last_int = ref_f2i(fv, fs);
    if (iv == 0)         ti = "R3";
    else if (iv == -512) ti = "R6";
    else                 ti = "R4,R5";
    sh = f2i_shift(fv, fs);
    if (fv[17] && last_int != 0) tf = "R9";
    else if (sh > 0)             tf = "R7";
    else                         tf = "R8";
    check_val(ti, $sformatf("i2f int=%0d scale=%0d", iv, is), 32'(float_out), 32'(last_fl));
    check_val(tf, $sformatf("f2i float=%h scale=%0d", fv, fs), 32'(int_out), 32'(last_int));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int scl[8] = '{0, 1, -1, 5, -9, -128, 100, 127};
    int fsc[3] = '{0, 3, -3};
    logic [8:0] mpat[4] = '{9'h100, 9'h1FF, 9'h155, 9'h000};
    int seed, iv, fs, e, k;
    logic [17:0] fv;
    int_in = 10'h155; float_in = 18'h3FFFF;
    repeat (3) @(negedge clk);
    check_val("R1", "reset float_out", 32'(float_out), 32'h0);
    check_val("R1", "reset int_out", 32'(int_out), 32'h0);
    rst = 1'b0;

    // full integer sweep at several scales; float side pseudo-random
    seed = 32'h1234567;
    for (int n = 0; n < 8192; n++) begin
      iv = n % 1024;
      if (iv >= 512) iv -= 1024;
      seed = seed * 1103515245 + 12345;
      e  = 120 + ((seed >>> 8) & 31);
      fs = ((seed >>> 20) & 31) - 16;
      fv = {seed[30], e[7:0], seed[8:0]};
      apply(iv, scl[n / 1024], fv, fs);
    end

    // full exponent sweep on the float side
    k = 0;
    for (int ex = 0; ex < 256; ex++)
      for (int sg = 0; sg < 2; sg++)
        for (int mp = 0; mp < 4; mp++)
          for (int sc = 0; sc < 3; sc++) begin
            iv = (k * 37) % 1024;
            if (iv >= 512) iv -= 1024;
            k++;
            apply(iv, scl[k % 8], {sg[0], ex[7:0], mpat[mp]}, fsc[sc]);
          end

    // R2: outputs hold until the next rising edge
    @(negedge clk);
    int_in = 10'd3; float_in = {1'b0, 8'd130, 9'h100}; float_scale = 8'd0; int_scale = 8'd0;
    #1;
    check_val("R2", "float_out held before edge", 32'(float_out), 32'(last_fl));
    check_val("R2", "int_out held before edge", 32'(int_out), 32'(last_int));
    @(negedge clk);
    check_val("R2", "float_out after edge", 32'(float_out), 32'(ref_i2f(3, 0)));
    check_val("R2", "int_out after edge", 32'(int_out), 32'(10'd2));
    finish_run();
  end
endmodule